// File: doc/BRIEF.md
# Single-Channel Byte DMA Engine

This block is one DMA channel. It moves bytes between a memory buffer and one fixed peripheral data address. It moves one byte for each request from the peripheral. Software programs a peripheral address, a memory start address and a byte count. It then sets the enable bit. From that point, each request from the peripheral causes one read and one write on a simple single-beat bus. The memory address then advances by one and the remaining count drops by one.

The channel sends two timing strobes back to the peripheral. An end strobe marks the final byte. When the programmed count is two or more, an early strobe marks the byte that leaves exactly one byte still to move, so the peripheral can prepare its last-byte handling. A half-way flag and a completion flag are kept in a flag register. Each flag drives its own interrupt output when its enable bit is set. Software clears the flags by writing ones to them.

The engine is a five-state machine:
- `ST_IDLE`: disabled. It goes to `ST_WAIT` once the enable bit is set.
- `ST_WAIT`: armed. It goes to `ST_READ` on a peripheral request, or back to `ST_IDLE` if software clears the enable bit.
- `ST_READ`: the source read is on the bus. It goes to `ST_WRITE` on bus acknowledge, keeping the returned byte.
- `ST_WRITE`: the destination write is on the bus. It goes to `ST_UPDATE` on bus acknowledge.
- `ST_UPDATE`: a single cycle. It acknowledges the request, steps the count and the address, and drives the strobes and flag sets. It goes to `ST_IDLE` after the last byte or when disabled, and to `ST_WAIT` otherwise.

Top module: `dma_chan_top`

## Requirements
- R1: Control bit 1 (`dir`) selects the direction. With dir=1, each byte is read from the memory address and written to the peripheral address. With dir=0, it is read from the peripheral address and written to the memory address. The written byte equals the byte read.
- R2: The memory address rises by one after every byte, and the register at word offset 2 reads back the advanced value. The peripheral address never changes.
- R3: Each peripheral request that is served produces exactly one read, one write and a one-cycle `per_ack`. The count register at word offset 3 then drops by one.
- R4: On the byte that brings the count to zero, `per_eot` pulses for one cycle in the same cycle as `per_ack`. The completion flag (flag bit 1) sets, and the enable bit (control bit 0) clears by itself.
- R5: `per_eot1` pulses once, on the byte that leaves one byte remaining, only when the count at enable time was two or more. It never pulses together with `per_eot`.
- R6: The half flag (flag bit 0) sets on the byte that leaves floor(N/2) bytes remaining, where N is the count at enable time.
- R7: `irq_half` is flag bit 0 AND control bit 2. `irq_done` is flag bit 1 AND control bit 3. A flag still sets while its interrupt enable is low.
- R8: Control bits 5:4 hold a two-bit priority. It is stored and read back unchanged and has no other effect.
- R9: While the channel is enabled, writes to the peripheral address (offset 1), memory address (offset 2) and count (offset 3) are ignored. A write that sets the enable bit while the count is zero is ignored too.
- R10: Writing to word offset 4 clears each flag whose bit in the written data is one. Reading offset 4 returns the flags.
- R11: While the channel is disabled, peripheral requests cause no bus activity and no `per_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| per_req | input | 1 | Peripheral transfer request (level) |
| per_ack | output | 1 | Request served pulse |
| per_eot | output | 1 | Final-byte strobe |
| per_eot1 | output | 1 | One-byte-remaining strobe |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data |
| bus_ack | input | 1 | Bus access complete |
| irq_half | output | 1 | Half-way interrupt |
| irq_done | output | 1 | Completion interrupt |

## Verification
A wrong count or a missed memory-address step shows up at the bus on the very next write: the address or data differs from the scoreboard entry. The count and the memory-address register can also be read directly. A wrong enable or a wrong terminal decision shows up within one cycle of the last acknowledge. The end strobe appears in the wrong place, the enable bit fails to clear, or an extra bus read starts. A wrong half mark or a wrong last-but-one decision moves the matching strobe or flag by one or more acknowledges, and the bench counts acknowledges to catch this.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_WRITE,
        ST_UPDATE
    } xfer_state_e;

    localparam logic [2:0] OFS_CTRL  = 3'd0;
    localparam logic [2:0] OFS_PADDR = 3'd1;
    localparam logic [2:0] OFS_MADDR = 3'd2;
    localparam logic [2:0] OFS_COUNT = 3'd3;
    localparam logic [2:0] OFS_FLAGS = 3'd4;

    typedef struct packed {
        logic [1:0] prio;
        logic       done_ie;
        logic       half_ie;
        logic       dir;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          step_i,
    input  logic          half_set_i,
    input  logic          done_set_i,
    output ctrl_t         ctrl_o,
    output logic [AW-1:0] paddr_o,
    output logic [AW-1:0] maddr_o,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] half_mark_o,
    output logic          multi_o,
    output logic [1:0]    flags_o
);
    localparam int CTRL_W = $bits(ctrl_t);

    ctrl_t         ctrl_q;
    logic [AW-1:0] paddr_q;
    logic [AW-1:0] maddr_q;
    logic [CW-1:0] count_q;
    logic [CW-1:0] half_mark_q;
    logic          multi_q;
    logic [1:0]    flags_q;
    logic          wr_ctrl;
    logic          wr_open;
    logic          count_zero;
    ctrl_t         ctrl_wr;

    assign count_zero = (count_q == '0);
    assign wr_ctrl    = cfg_we && (cfg_addr == OFS_CTRL);
    assign wr_open    = cfg_we && !ctrl_q.en;

    always_comb begin
        ctrl_wr    = ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        ctrl_wr.en = cfg_wdata[0] && !count_zero;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            paddr_q     <= '0;
            maddr_q     <= '0;
            count_q     <= '0;
            half_mark_q <= '0;
            multi_q     <= 1'b0;
            flags_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_wr;
                if (ctrl_wr.en && !ctrl_q.en) begin
                    half_mark_q <= count_q >> 1;
                    multi_q     <= (count_q > CW'(1));
                end
            end
            if (wr_open && cfg_addr == OFS_PADDR) paddr_q <= cfg_wdata[AW-1:0];
            if (wr_open && cfg_addr == OFS_MADDR) maddr_q <= cfg_wdata[AW-1:0];
            if (wr_open && cfg_addr == OFS_COUNT) count_q <= cfg_wdata[CW-1:0];
            if (step_i) begin
                count_q <= count_q - CW'(1);
                maddr_q <= maddr_q + AW'(1);
                if (count_q == CW'(1)) ctrl_q.en <= 1'b0;
            end
            flags_q[0] <= (flags_q[0] && !(cfg_we && cfg_addr == OFS_FLAGS && cfg_wdata[0]))
                          || half_set_i;
            flags_q[1] <= (flags_q[1] && !(cfg_we && cfg_addr == OFS_FLAGS && cfg_wdata[1]))
                          || done_set_i;
        end
    end

    always_comb begin
        unique case (cfg_addr)
            OFS_CTRL:  cfg_rdata = 32'(ctrl_q);
            OFS_PADDR: cfg_rdata = 32'(paddr_q);
            OFS_MADDR: cfg_rdata = 32'(maddr_q);
            OFS_COUNT: cfg_rdata = 32'(count_q);
            OFS_FLAGS: cfg_rdata = 32'(flags_q);
            default:   cfg_rdata = '0;
        endcase
    end

    assign ctrl_o      = ctrl_q;
    assign paddr_o     = paddr_q;
    assign maddr_o     = maddr_q;
    assign count_o     = count_q;
    assign half_mark_o = half_mark_q;
    assign multi_o     = multi_q;
    assign flags_o     = flags_q;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> !count_zero) else $error("count stepped at zero"); // R3
    AST_PADDR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.en && $past(ctrl_q.en)) |-> $stable(paddr_q)) else $error("paddr moved while enabled"); // R9
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> (maddr_q == $past(maddr_q) + AW'(1))) else $error("maddr did not advance"); // R2

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          dir_i,
    input  logic [AW-1:0] paddr_i,
    input  logic [AW-1:0] maddr_i,
    input  logic [CW-1:0] count_i,
    input  logic [CW-1:0] half_mark_i,
    input  logic          multi_i,
    input  logic          per_req_i,
    output logic          per_ack_o,
    output logic          eot_o,
    output logic          eot1_o,
    output logic          step_o,
    output logic          half_set_o,
    output logic          done_set_o,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [7:0]    bus_wdata_o,
    input  logic [7:0]    bus_rdata_i,
    input  logic          bus_ack_i
);
    xfer_state_e state_q, state_d;
    logic [7:0]  byte_q;
    logic        last_byte;

    assign last_byte = (count_i == CW'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en_i) state_d = ST_WAIT;
            ST_WAIT:   if (!en_i) state_d = ST_IDLE;
                       else if (per_req_i) state_d = ST_READ;
            ST_READ:   if (bus_ack_i) state_d = ST_WRITE;
            ST_WRITE:  if (bus_ack_i) state_d = ST_UPDATE;
            ST_UPDATE: state_d = (last_byte || !en_i) ? ST_IDLE : ST_WAIT;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                              byte_q <= '0;
        else if (state_q == ST_READ && bus_ack_i) byte_q <= bus_rdata_i;
    end

    always_comb begin
        per_ack_o   = 1'b0;
        eot_o       = 1'b0;
        eot1_o      = 1'b0;
        step_o      = 1'b0;
        half_set_o  = 1'b0;
        done_set_o  = 1'b0;
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (state_q)
            ST_IDLE, ST_WAIT: ;
            ST_READ: begin
                bus_req_o  = 1'b1;
                bus_addr_o = dir_i ? maddr_i : paddr_i;
            end
            ST_WRITE: begin
                bus_req_o   = 1'b1;
                bus_we_o    = 1'b1;
                bus_addr_o  = dir_i ? paddr_i : maddr_i;
                bus_wdata_o = byte_q;
            end
            ST_UPDATE: begin
                per_ack_o  = 1'b1;
                step_o     = 1'b1;
                eot_o      = last_byte;
                done_set_o = last_byte;
                eot1_o     = multi_i && (count_i == CW'(2));
                half_set_o = ((count_i - CW'(1)) == half_mark_i);
            end
            default: ;
        endcase
    end

    AST_EN_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        eot_o |=> !en_i) else $error("enable stayed set after end"); // R4
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        eot1_o |-> !eot_o) else $error("both strobes together"); // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)))
        else $error("bus access changed before ack"); // R1
    AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req_o) |-> en_i) else $error("bus started while disabled"); // R11

endmodule

// File: rtl/dma_chan_top.sv
module dma_chan_top
    import dma_chan_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          per_req,
    output logic          per_ack,
    output logic          per_eot,
    output logic          per_eot1,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    input  logic [7:0]    bus_rdata,
    input  logic          bus_ack,
    output logic          irq_half,
    output logic          irq_done
);
    ctrl_t         ctrl;
    logic [AW-1:0] paddr;
    logic [AW-1:0] maddr;
    logic [CW-1:0] count;
    logic [CW-1:0] half_mark;
    logic          multi;
    logic [1:0]    flags;
    logic          step;
    logic          half_set;
    logic          done_set;

    dma_chan_regs #(.AW(AW), .CW(CW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .step_i     (step),
        .half_set_i (half_set),
        .done_set_i (done_set),
        .ctrl_o     (ctrl),
        .paddr_o    (paddr),
        .maddr_o    (maddr),
        .count_o    (count),
        .half_mark_o(half_mark),
        .multi_o    (multi),
        .flags_o    (flags)
    );

    dma_chan_fsm #(.AW(AW), .CW(CW)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (ctrl.en),
        .dir_i       (ctrl.dir),
        .paddr_i     (paddr),
        .maddr_i     (maddr),
        .count_i     (count),
        .half_mark_i (half_mark),
        .multi_i     (multi),
        .per_req_i   (per_req),
        .per_ack_o   (per_ack),
        .eot_o       (per_eot),
        .eot1_o      (per_eot1),
        .step_o      (step),
        .half_set_o  (half_set),
        .done_set_o  (done_set),
        .bus_req_o   (bus_req),
        .bus_we_o    (bus_we),
        .bus_addr_o  (bus_addr),
        .bus_wdata_o (bus_wdata),
        .bus_rdata_i (bus_rdata),
        .bus_ack_i   (bus_ack)
    );

    assign irq_half = flags[0] && ctrl.half_ie;
    assign irq_done = flags[1] && ctrl.done_ie;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_half || irq_done) |-> (flags != 2'b00)) else $error("irq without flag"); // R7

endmodule

// File: tb/dma_chan_top_tb_top.sv
module dma_chan_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          per_req = 1'b0;
    logic          per_ack, per_eot, per_eot1;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic [7:0]    bus_rdata = '0;
    logic          bus_ack = 1'b0;
    logic          irq_half, irq_done;

    int errors = 0;
    int checks = 0;
    int acks = 0, eot_n = 0, eot_at = 0, eot1_n = 0, eot1_at = 0, half_at = 0, bus_cyc = 0;
    logic [23:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_top #(.AW(AW), .CW(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .per_req(per_req),
        .per_ack(per_ack), .per_eot(per_eot), .per_eot1(per_eot1),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .irq_half(irq_half), .irq_done(irq_done)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: bus responder and scoreboard consumer
    always @(negedge clk) begin
        if (rst_n) begin
            if (per_ack) acks++;
            if (per_eot) begin eot_n++; eot_at = acks; end
            if (per_eot1) begin eot1_n++; eot1_at = acks; end
            if (irq_half && half_at == 0) half_at = acks;
            if (bus_req) bus_cyc++;
            if (bus_req && !bus_ack) begin
                bus_ack = 1'b1;
                if (bus_we) begin
                    if (expq.size() == 0) check("R1 unexpected write", {8'h0, bus_addr, bus_wdata}, 32'h0);
                    else check("R1/R2 write addr+data", {8'h0, bus_addr, bus_wdata}, {8'h0, expq.pop_front()});
                end else begin
                    bus_rdata = bus_addr[7:0] ^ 8'hA5;
                end
            end else begin
                bus_ack = 1'b0;
            end
        end
    end

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Driver: programs a run, pushes expected writes, serves requests
    task automatic run(bit dir, logic [15:0] pa, logic [15:0] ma, int n,
                       bit hie, bit die, logic [1:0] prio, bit poke);
        logic [31:0] v;
        logic [15:0] m;
        wr(3'd1, 32'(pa));
        wr(3'd2, 32'(ma));
        wr(3'd3, n);
        wr(3'd4, 32'h3);
        acks = 0; eot_n = 0; eot_at = 0; eot1_n = 0; eot1_at = 0; half_at = 0;
        for (int i = 0; i < n; i++) begin
            m = ma + 16'(i);
            if (dir) expq.push_back({pa, m[7:0] ^ 8'hA5});
            else     expq.push_back({m, pa[7:0] ^ 8'hA5});
        end
        wr(3'd0, {26'd0, prio, die, hie, dir, 1'b1});
        if (poke) begin
            wr(3'd1, 32'h0000_BEEF);   // R9 ignored
            wr(3'd3, 32'd77);          // R9 ignored
            rd(3'd3, v); check("R9 count write ignored", v, 32'(n));
        end
        for (int i = 0; i < n; i++) begin
            per_req = 1'b1;
            do @(negedge clk); while (!per_ack);
            per_req = 1'b0;
            if (i == 0 && n > 2) begin
                rd(3'd3, v); check("R3 count after one byte", v, 32'(n - 1));
                rd(3'd2, v); check("R2 maddr after one byte", v, 32'(ma + 16'd1));
            end
        end
        repeat (4) @(negedge clk);
        check("R3 queue drained", expq.size(), 0);
        check("R3 acks", acks, n);
        check("R4 one eot", eot_n, 1);
        check("R4 eot on last ack", eot_at, n);
        check("R5 eot1 count", eot1_n, (n >= 2) ? 1 : 0);
        if (n >= 2) check("R5 eot1 position", eot1_at, n - 1);
        rd(3'd3, v); check("R4 count zero", v, 0);
        rd(3'd0, v); check("R8 ctrl readback, R4 enable cleared", v, {26'd0, prio, die, hie, dir, 1'b0});
        rd(3'd2, v); check("R2 maddr final", v, 32'(ma + 16'(n)));
        rd(3'd1, v); check("R2/R9 paddr fixed", v, 32'(pa));
        rd(3'd4, v); check("R4/R6 flags", v, 32'h3);
        check("R7 irq_half gating", irq_half, hie);
        check("R7 irq_done gating", irq_done, die);
        if (hie) check("R6 half position", half_at, n - n / 2);
        else     check("R7 no half irq", half_at, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(3'd0, v); check("R8 reset ctrl", v, 0);
        rd(3'd4, v); check("R10 reset flags", v, 0);
        check("R11 reset strobes", {per_ack, per_eot, per_eot1, bus_req}, 0);

        // R11: request while disabled
        bus_cyc = 0; acks = 0;
        per_req = 1'b1;
        repeat (10) @(negedge clk);
        per_req = 1'b0;
        check("R11 no bus while disabled", bus_cyc, 0);
        check("R11 no ack while disabled", acks, 0);

        // R9: enable with zero count ignored
        wr(3'd0, 32'h1);
        rd(3'd0, v); check("R9 enable with zero count", v[0], 0);

        run(1'b1, 16'h4000, 16'h0100, 5, 1'b1, 1'b1, 2'd2, 1'b1);
        // R10: write-one-to-clear each flag separately
        wr(3'd4, 32'h1);
        rd(3'd4, v); check("R10 clear half only", v, 32'h2);
        wr(3'd4, 32'h2);
        rd(3'd4, v); check("R10 clear done", v, 32'h0);

        run(1'b0, 16'h4010, 16'h0200, 4, 1'b0, 1'b1, 2'd1, 1'b0);
        run(1'b1, 16'h4020, 16'h03F0, 1, 1'b1, 1'b0, 2'd3, 1'b0);
        run(1'b0, 16'h4030, 16'h0080, 2, 1'b1, 1'b1, 2'd0, 1'b1);
        run(1'b1, 16'h4040, 16'h00FE, 7, 1'b1, 1'b1, 2'd1, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule